// File: doc/BRIEF.md
# Condition-Code Flag Unit

This block keeps the eight-bit condition-code register of a small accumulator processor. It works out the negative, zero, overflow and carry flags for 8-bit and 16-bit operations. The execution datapath hands over the two operands, the result it already formed, the class of operation, a width select and an update strobe. Carry and overflow are rebuilt from the sign bits of the operands and the result. The block never needs the adder's own carry chain. For shifts, the datapath also supplies the bit shifted out, and that bit becomes the carry.

Separate per-bit write controls let the processor force any single flag, or any group of flags, to a chosen value. The control flags (stop-disable, external-interrupt mask, half-carry, interrupt mask) are changed only through these writes. Arithmetic updates never touch them. The register value is visible on the clock edge that follows the request.

Top module: `cc_flag_unit`

## Requirements
- R1: While reset is held, and on the first edge after it is released, the register reads 0xD0. The bit order from bit 7 down to bit 0 is S, X, H, I, N, Z, V, C, so the reset value has S, X and I set and all other bits clear.
- R2: A cycle with the strobe low and an all-zero write mask leaves the register unchanged.
- R3: Class add (op_sel = 00). C takes the top bit of (a&b)|(b&~r)|(a&~r), and V takes the top bit of (a&b&~r)|(~a&~b&r). When r = a+b, these are the unsigned carry-out and the signed overflow.
- R4: Class subtract (op_sel = 01). C takes the top bit of (~a&b)|(b&r)|(~a&r), and V takes the top bit of (a&~b&~r)|(~a&b&r). When r = a−b, these are the unsigned borrow and the signed overflow.
- R5: For every class, N is the top bit of the result and Z is set when the result is zero. The top bit is bit 7 when wide_sel = 0 and bit 15 when wide_sel = 1. In 8-bit mode the upper bytes of the operands and the result have no effect.
- R6: Class shift (op_sel = 10). C takes shift_cout, and V takes N XOR C.
- R7: Class test (op_sel = 11). V is cleared and C keeps its previous value.
- R8: A strobed update never changes bits 7 to 4 (S, X, H, I).
- R9: Each bit whose flag_wr_mask bit is set takes the matching bit of flag_wr_val on the next edge. All other bits are left alone by this write. On a bit that the mask selects, the write wins over a strobed update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_en | input | 1 | Update strobe for the N, Z, V and C flags |
| op_sel | input | 2 | Operation class: 00 add, 01 subtract, 10 shift, 11 test |
| wide_sel | input | 1 | 0 selects 8-bit flags, 1 selects 16-bit flags |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| result | input | 16 | Result formed by the datapath |
| shift_cout | input | 1 | Bit shifted out by a shift operation |
| flag_wr_mask | input | 8 | Per-bit write select |
| flag_wr_val | input | 8 | Per-bit write value |
| ccr_q | output | 8 | Condition-code register |

## Verification
Every result of this block sits in the single register stage. A request driven before edge k therefore shows up on ccr_q right after edge k, and no result is due on any later cycle. The bench drives each request at a falling edge. At the next falling edge it compares ccr_q with its own model of the register, then drives the next request. This way every clock is compared and no comparison sits at an edge. The bench works out carry and overflow from true unsigned and signed sums and differences, not from the sign-bit formulas. Its directed cases cover the wrap and zero boundaries in both widths.

// File: rtl/cc_pkg.sv
package cc_pkg;

  typedef enum logic [1:0] {
    OP_ADD   = 2'b00,
    OP_SUB   = 2'b01,
    OP_SHIFT = 2'b10,
    OP_TEST  = 2'b11
  } op_class_e;

  localparam int CCR_W = 8;
  localparam int BIT_C = 0;
  localparam int BIT_V = 1;
  localparam int BIT_Z = 2;
  localparam int BIT_N = 3;
  localparam int ARITH_BITS = 4;
  localparam logic [CCR_W-1:0] CCR_RESET = 8'hD0;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } nzvc_t;

endpackage

// File: rtl/cc_flag_calc.sv
module cc_flag_calc
  import cc_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  op_class_e         op,
  input  logic              wide,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] r,
  input  logic              shift_c,
  input  logic              c_now,
  output nzvc_t             flags
);

  localparam int NUM_WIDTHS = 2;

  // Bitwise reconstruction vectors; the bit at the active MSB is the flag.
  function automatic logic [DATA_W-1:0] add_c_vec(input logic [DATA_W-1:0] x, y, s);
    return (x & y) | (y & ~s) | (x & ~s);
  endfunction

  function automatic logic [DATA_W-1:0] add_v_vec(input logic [DATA_W-1:0] x, y, s);
    return (x & y & ~s) | (~x & ~y & s);
  endfunction

  function automatic logic [DATA_W-1:0] sub_c_vec(input logic [DATA_W-1:0] x, y, s);
    return (~x & y) | (y & s) | (~x & s);
  endfunction

  function automatic logic [DATA_W-1:0] sub_v_vec(input logic [DATA_W-1:0] x, y, s);
    return (x & ~y & ~s) | (~x & y & s);
  endfunction

  function automatic nzvc_t pick_flags(input op_class_e o, input logic n, z,
                                       input logic ac, av, sc, sv, shc, cur_c);
    nzvc_t f;
    f.n = n;
    f.z = z;
    unique case (o)
      OP_ADD:   begin f.c = ac;    f.v = av;      end
      OP_SUB:   begin f.c = sc;    f.v = sv;      end
      OP_SHIFT: begin f.c = shc;   f.v = n ^ shc; end
      default:  begin f.c = cur_c; f.v = 1'b0;    end
    endcase
    return f;
  endfunction

  logic [DATA_W-1:0] ac_vec, av_vec, sc_vec, sv_vec;
  assign ac_vec = add_c_vec(a, b, r);
  assign av_vec = add_v_vec(a, b, r);
  assign sc_vec = sub_c_vec(a, b, r);
  assign sv_vec = sub_v_vec(a, b, r);

  nzvc_t per_width [NUM_WIDTHS];

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
    localparam int W = (g == 0) ? NARROW_W : DATA_W;
    logic msb_r, zero_r;
    assign msb_r  = r[W-1];
    assign zero_r = (r[W-1:0] == '0);
    assign per_width[g] = pick_flags(op, msb_r, zero_r,
                                     ac_vec[W-1], av_vec[W-1],
                                     sc_vec[W-1], sv_vec[W-1],
                                     shift_c, c_now);
  end

  assign flags = wide ? per_width[1] : per_width[0];

endmodule

// File: rtl/cc_reg.sv
module cc_reg
  import cc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  nzvc_t            arith,
  input  logic [CCR_W-1:0] wr_mask,
  input  logic [CCR_W-1:0] wr_val,
  output logic [CCR_W-1:0] q
);

  logic [CCR_W-1:0] arith_wide;
  logic [CCR_W-1:0] d;

  assign arith_wide = {{(CCR_W-ARITH_BITS){1'b0}}, arith};

  for (genvar i = 0; i < CCR_W; i++) begin : g_bit
    if (i < ARITH_BITS) begin : g_arith
      assign d[i] = wr_mask[i] ? wr_val[i] : (upd ? arith_wide[i] : q[i]);
    end else begin : g_ctrl
      assign d[i] = wr_mask[i] ? wr_val[i] : q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= CCR_RESET;
    else        q <= d;
  end

endmodule

// File: rtl/cc_flag_unit.sv
module cc_flag_unit
  import cc_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [1:0]        op_sel,
  input  logic              wide_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] result,
  input  logic              shift_cout,
  input  logic [7:0]        flag_wr_mask,
  input  logic [7:0]        flag_wr_val,
  output logic [7:0]        ccr_q
);

  op_class_e op_cls;
  nzvc_t     calc_flags;
  logic      cur_carry;

  assign op_cls    = op_class_e'(op_sel);
  assign cur_carry = ccr_q[BIT_C];

  cc_flag_calc #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_calc (
    .op      (op_cls),
    .wide    (wide_sel),
    .a       (opnd_a),
    .b       (opnd_b),
    .r       (result),
    .shift_c (shift_cout),
    .c_now   (cur_carry),
    .flags   (calc_flags)
  );

  cc_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (upd_en),
    .arith   (calc_flags),
    .wr_mask (flag_wr_mask),
    .wr_val  (flag_wr_val),
    .q       (ccr_q)
  );

endmodule

// File: rtl/cc_flag_unit_chk.sv
module cc_flag_unit_chk
  import cc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       upd_en,
  input logic [1:0] op_sel,
  input logic [7:0] flag_wr_mask,
  input logic [7:0] flag_wr_val,
  input logic [7:0] ccr_q,
  input nzvc_t      calc_flags
);

  // R1
  a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ccr_q == 8'hD0);

  // R2
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && flag_wr_mask == 8'h00) |=> $stable(ccr_q));

  // R5
  a_r5_z_from_calc: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !flag_wr_mask[2]) |=> ccr_q[2] == $past(calc_flags.z));

  // R5: a zero result is never negative
  a_r5_zn_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && flag_wr_mask[3:2] == 2'b00) |=> !(ccr_q[2] && ccr_q[3]));

  // R6
  a_r6_shift_v: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_sel == 2'b10 && flag_wr_mask[3:0] == 4'h0)
      |=> ccr_q[1] == (ccr_q[3] ^ ccr_q[0]));

  // R7
  a_r7_test_keeps_c: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_sel == 2'b11 && flag_wr_mask[1:0] == 2'b00)
      |=> (ccr_q[0] == $past(ccr_q[0])) && !ccr_q[1]);

  // R8
  a_r8_ctrl_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr_mask[7:4] == 4'h0) |=> ccr_q[7:4] == $past(ccr_q[7:4]));

  // R9
  a_r9_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr_mask != 8'h00)
      |=> (ccr_q & $past(flag_wr_mask)) == ($past(flag_wr_val) & $past(flag_wr_mask)));

endmodule

bind cc_flag_unit cc_flag_unit_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .upd_en       (upd_en),
  .op_sel       (op_sel),
  .flag_wr_mask (flag_wr_mask),
  .flag_wr_val  (flag_wr_val),
  .ccr_q        (ccr_q),
  .calc_flags   (calc_flags)
);

// File: tb/sim_cc_flag_unit.sv
module sim_cc_flag_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd_en;
  logic [1:0]  op_sel;
  logic        wide_sel;
  logic [15:0] opnd_a, opnd_b, result;
  logic        shift_cout;
  logic [7:0]  flag_wr_mask, flag_wr_val;
  logic [7:0]  ccr_q;

  always #5 clk = ~clk;

  cc_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_sel(op_sel),
    .wide_sel(wide_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
    .shift_cout(shift_cout), .flag_wr_mask(flag_wr_mask),
    .flag_wr_val(flag_wr_val), .ccr_q(ccr_q)
  );

  int n_run  = 0;
  int n_fail = 0;
  logic [7:0] exp_ccr;

  // Behavioural model: carry/overflow from true integer arithmetic.
  function automatic logic [7:0] ref_next(input logic [7:0] cur, input logic en,
      input int op, input logic wd, input int a, b, r, input logic shc,
      input logic [7:0] wm, wv);
    int w    = wd ? 16 : 8;
    int m    = (1 << w) - 1;
    int half = 1 << (w - 1);
    int aa = a & m, bb = b & m, rr = r & m;
    int sa = (aa >= half) ? aa - (1 << w) : aa;
    int sb = (bb >= half) ? bb - (1 << w) : bb;
    logic n = (rr & half) != 0;
    logic z = (rr == 0);
    logic v, c;
    logic [7:0] nx = cur;
    case (op)
      0: begin c = (aa + bb) > m; v = ((sa + sb) >= half) || ((sa + sb) < -half); end
      1: begin c = aa < bb;       v = ((sa - sb) >= half) || ((sa - sb) < -half); end
      2: begin c = shc;           v = n ^ shc; end
      default: begin c = cur[0];  v = 1'b0; end
    endcase
    if (en) nx[3:0] = {n, z, v, c};
    nx = (nx & ~wm) | (wv & wm);
    return nx;
  endfunction

  task automatic check(input string tag);
    n_run++;
    if (ccr_q !== exp_ccr) begin
      n_fail++;
      $display("FAIL %s: ccr_q=%02h expected %02h", tag, ccr_q, exp_ccr);
    end
  endtask

  // Called at a falling edge: drive, advance model, compare one edge later.
  task automatic step(input logic en, input int op, input logic wd,
      input int a, b, r, input logic shc, input logic [7:0] wm, wv,
      input string tag);
    upd_en = en; op_sel = op[1:0]; wide_sel = wd;
    opnd_a = a[15:0]; opnd_b = b[15:0]; result = r[15:0];
    shift_cout = shc; flag_wr_mask = wm; flag_wr_val = wv;
    exp_ccr = ref_next(exp_ccr, en, op, wd, a, b, r, shc, wm, wv);
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_add(input logic wd, input int a, b, input string tag);
    step(1'b1, 0, wd, a, b, (a + b) & 16'hFFFF, 1'b0, 8'h00, 8'h00, tag);
  endtask

  task automatic do_sub(input logic wd, input int a, b, input string tag);
    step(1'b1, 1, wd, a, b, (a - b) & 16'hFFFF, 1'b0, 8'h00, 8'h00, tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; upd_en = 1'b0; op_sel = 2'b00; wide_sel = 1'b0;
    opnd_a = '0; opnd_b = '0; result = '0; shift_cout = 1'b0;
    flag_wr_mask = '0; flag_wr_val = '0;
    exp_ccr = 8'hD0;
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    step(1'b0, 0, 1'b0, 16'h00FF, 16'h0001, 0, 1'b1, 8'h00, 8'h00, "R1 first edge idle");
    step(1'b0, 2, 1'b1, 16'h1234, 16'h5678, 16'h0000, 1'b1, 8'h00, 8'h00, "R2 no strobe");

    do_add(1'b0, 16'h007F, 16'h0001, "R3 8-bit signed overflow");
    do_add(1'b0, 16'h00FF, 16'h0001, "R3 8-bit carry to zero");
    do_add(1'b1, 16'h8000, 16'h8000, "R3 16-bit carry and overflow");
    do_add(1'b1, 16'h7FFF, 16'h0001, "R3 16-bit overflow");
    do_sub(1'b0, 16'h0000, 16'h0001, "R4 8-bit borrow");
    do_sub(1'b0, 16'h0080, 16'h0001, "R4 8-bit overflow");
    do_sub(1'b1, 16'h1234, 16'h1234, "R4 16-bit equal");
    do_sub(1'b1, 16'h8000, 16'h0001, "R4 16-bit overflow");
    do_add(1'b0, 16'hAB7F, 16'h3401, "R5 8-bit upper bytes ignored");
    step(1'b1, 3, 1'b0, 0, 0, 16'hAB00, 1'b0, 8'h00, 8'h00, "R5 8-bit zero test");
    step(1'b1, 3, 1'b1, 0, 0, 16'h8000, 1'b0, 8'h00, 8'h00, "R5 16-bit negative");
    step(1'b1, 2, 1'b0, 0, 0, 16'h0080, 1'b0, 8'h00, 8'h00, "R6 shift N=1 C=0");
    step(1'b1, 2, 1'b1, 0, 0, 16'h8000, 1'b1, 8'h00, 8'h00, "R6 shift N=1 C=1");
    step(1'b1, 2, 1'b0, 0, 0, 16'h0000, 1'b1, 8'h00, 8'h00, "R6 shift zero C=1");
    do_add(1'b0, 16'h00FF, 16'h0002, "R3 set carry");
    step(1'b1, 3, 1'b0, 0, 0, 16'h0040, 1'b0, 8'h00, 8'h00, "R7 test keeps C=1");
    step(1'b1, 3, 1'b1, 0, 0, 16'h0001, 1'b0, 8'h00, 8'h00, "R7 test keeps C again");
    step(1'b0, 0, 1'b0, 0, 0, 0, 1'b0, 8'hF0, 8'h20, "R9 control bits write");
    do_add(1'b1, 16'hFFFF, 16'hFFFF, "R8 control bits after add");
    step(1'b1, 2, 1'b0, 0, 0, 16'h00C0, 1'b1, 8'h00, 8'h00, "R8 control bits after shift");
    step(1'b1, 0, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 1'b0, 8'h05, 8'h00, "R9 write beats strobe");
    step(1'b0, 0, 1'b0, 0, 0, 0, 1'b0, 8'h80, 8'hFF, "R9 single bit write");

    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 3);
      logic en = ($urandom_range(0, 3) != 0);
      logic wd = $urandom_range(0, 1);
      int a = $urandom_range(0, 16'hFFFF);
      int b = $urandom_range(0, 16'hFFFF);
      int r = $urandom_range(0, 16'hFFFF);
      logic [7:0] wm = ($urandom_range(0, 5) == 0) ? 8'($urandom_range(0, 255)) : 8'h00;
      logic [7:0] wv = 8'($urandom_range(0, 255));
      logic shc = $urandom_range(0, 1);
      string tag;
      if (op == 0) r = (a + b) & 16'hFFFF;
      if (op == 1) r = (a - b) & 16'hFFFF;
      case (op)
        0: tag = "R3 random add";
        1: tag = "R4 random sub";
        2: tag = "R6 random shift";
        default: tag = "R7 random test";
      endcase
      if (!en)      tag = "R2 random idle";
      if (wm != 0)  tag = "R9 random write";
      step(en, op, wd, a, b, r, shc, wm, wv, tag);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule